// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers four shared PCI interrupt request lines onto sixteen legacy interrupt-controller inputs. Each shared line owns one 8-bit steering byte. A value below 16 selects the controller input that the line drives. A value of 16 or above disconnects the line. The steering bytes sit in one 32-bit word of a byte-addressed configuration port, which has byte-lane write enables and a combinational read.

Internally the block keeps a 64-bit level map with one bit for each pairing of controller input and shared line. Each controller input is the OR of its four map bits. Any configuration write that lands on a steering byte clears the map and rebuilds it from the live line levels, using the new steering values. Outside of such writes, only the bit at a line's current route follows that line's level.

Two small combinational helpers complete the block. The first folds a device's slot number and INTx pin into a shared-line index. The second reports whether a given line is routed, and to which input.

Top module: `pirq_steer`

## Requirements
- R1: After a synchronous active-high reset, every steering byte reads 0x80 and all sixteen `irq_out` bits are low.
- R2: A write with `cfg_addr[7:2] == 6'h18` stores `cfg_wdata[8i+7:8i]` as the steering byte of line i (i = 0..3 for A..D) only where `cfg_be[i]` is set. Writes to any other word, and lanes whose enable is clear, leave the steering bytes and outputs untouched.
- R3: A read of the word at `cfg_addr[7:2] == 6'h18` returns the four steering bytes, with line A in bits 7:0 and line D in bits 31:24. Every other address reads as zero.
- R4: When line p has a steering byte v < 16 and its level is high, `irq_out[v]` is high one clock edge after the level is presented.
- R5: An interrupt output is the OR of every line currently steered to it, so several lines may share one output.
- R6: A line whose steering byte is 16 or above never drives any output, whatever its level.
- R7: On the clock edge of a write that hits the steering word, the map is rebuilt from the current levels and the new steering bytes. An output that lost its last routed line drops at that same edge.
- R8: `pirq_idx` equals (`intx_pin` + `slot` - 1) mod 4, where `intx_pin` 0..3 stands for INTA..INTD.
- R9: `q_en` is high exactly when the steering byte of line `q_pin` is below 16. `q_irq` then carries that byte's low four bits, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pirq_lvl | input | 4 | Levels of shared lines A..D (bit 0 = A) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Write data, byte lane i at bits 8i+7:8i |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_rdata | output | 32 | Read data of the word at cfg_addr |
| irq_out | output | 16 | Interrupt-controller input levels |
| slot | input | 5 | Device slot number for the pin fold |
| intx_pin | input | 2 | Device INTx pin for the pin fold |
| pirq_idx | output | 2 | Shared-line index for slot and pin |
| q_pin | input | 2 | Line selected for the route query |
| q_en | output | 1 | Selected line is routed |
| q_irq | output | 4 | Output the selected line is routed to |

## Verification
All sixteen level patterns are applied under each of five steering layouts:
- all lines disconnected, which shows that disconnected lines are blocked;
- four distinct targets, which shows that each line reaches its own output;
- every line on one output, which shows the OR on a shared input;
- a mix of 0x00, 0x0F, 0x10 and 0xFF, which separates the edges of the enable threshold;
- a partly shared, partly disabled layout.

Each line's steering byte is then swept from 0 to 39 with all lines high, and the route query is checked at the same time. A re-steering write is checked at its own edge, which separates a rebuild from a map update that only follows level changes. Every configuration address is read back, and the pin fold is checked across all slot and pin pairs.

// File: rtl/pirq_steer.sv
module pirq_steer #(
  parameter int NIRQ = 16,
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  pirq_lvl,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  output logic [31:0] cfg_rdata,
  output logic [NIRQ-1:0] irq_out,
  input  logic [4:0]  slot,
  input  logic [1:0]  intx_pin,
  output logic [1:0]  pirq_idx,
  input  logic [1:0]  q_pin,
  output logic        q_en,
  output logic [$clog2(NIRQ)-1:0] q_irq
);
  localparam int IRQW = $clog2(NIRQ);
  localparam int MAPW = NIRQ * 4;
  localparam logic [7:0] LIMIT = 8'(NIRQ);
  localparam logic [5:0] BASE_DW = ROUTE_BASE[7:2];

  logic [3:0][7:0] route_q, route_d;
  logic [MAPW-1:0] lvl_map, map_d;
  logic            wr_hit;

  assign wr_hit = cfg_wr && (cfg_addr[7:2] == BASE_DW) && (|cfg_be);

  always_comb begin
    for (int i = 0; i < 4; i++)
      route_d[i] = (wr_hit && cfg_be[i]) ? cfg_wdata[8*i +: 8] : route_q[i];
  end

  always_comb begin
    logic [IRQW+1:0] idx;
    map_d = wr_hit ? '0 : lvl_map;
    for (int p = 0; p < 4; p++) begin
      idx = {route_d[p][IRQW-1:0], 2'(p)};
      if (route_d[p] < LIMIT) map_d[idx] = pirq_lvl[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= {4{8'h80}};
      lvl_map <= '0;
    end else begin
      route_q <= route_d;
      lvl_map <= map_d;
    end
  end

  for (genvar n = 0; n < NIRQ; n++) begin : g_or
    assign irq_out[n] = |lvl_map[4*n +: 4];
  end

  assign cfg_rdata = (cfg_addr[7:2] == BASE_DW) ? route_q : 32'h0;
  assign pirq_idx  = intx_pin + slot[1:0] + 2'd3;
  assign q_en      = route_q[q_pin] < LIMIT;
  assign q_irq     = q_en ? route_q[q_pin][IRQW-1:0] : '0;
endmodule

// File: rtl/pirq_steer_chk.sv
module pirq_steer_chk #(
  parameter int NIRQ = 16,
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      pirq_lvl,
  input logic [7:0]      cfg_addr,
  input logic [31:0]     cfg_rdata,
  input logic [NIRQ-1:0] irq_out,
  input logic [3:0][7:0] route_q,
  input logic            wr_hit
);
  localparam logic [7:0] LIMIT = 8'(NIRQ);
  localparam int IRQW = $clog2(NIRQ);

  for (genvar p = 0; p < 4; p++) begin : g_line
    // R4
    routed_lvl_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_hit && route_q[p] < LIMIT && pirq_lvl[p]) |=> irq_out[$past(route_q[p][IRQW-1:0])]);
  end

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && route_q[0] >= LIMIT && route_q[1] >= LIMIT &&
     route_q[2] >= LIMIT && route_q[3] >= LIMIT) |=> (irq_out == '0));

  // R5
  all_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && pirq_lvl == 4'b0) |=> (irq_out == '0));

  // R2
  route_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(route_q));

  // R3
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr[7:2] != ROUTE_BASE[7:2]) |-> (cfg_rdata == 32'h0));
endmodule

bind pirq_steer pirq_steer_chk #(.NIRQ(NIRQ), .ROUTE_BASE(ROUTE_BASE)) u_chk (
  .clk(clk), .rst(rst), .pirq_lvl(pirq_lvl), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .irq_out(irq_out), .route_q(route_q), .wr_hit(wr_hit)
);

// File: tb/pirq_steer_tb.sv
module pirq_steer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic [3:0]  pirq_lvl = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 8'h60;
  logic [31:0] cfg_wdata = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_rdata;
  logic [15:0] irq_out;
  logic [4:0]  slot = 0;
  logic [1:0]  intx_pin = 0, pirq_idx, q_pin = 0;
  logic        q_en;
  logic [3:0]  q_irq;

  int vecs = 0, bad = 0;
  logic [7:0] mr [4];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_steer u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    step();
    cfg_wr = 0; cfg_addr = 8'h60;
    if (a[7:2] == 6'h18)
      for (int i = 0; i < 4; i++) if (be[i]) mr[i] = d[8*i +: 8];
  endtask

  function automatic logic [15:0] exp_irq(logic [3:0] lv);
    logic [15:0] e = 0;
    for (int p = 0; p < 4; p++)
      if (mr[p] < 16 && lv[p]) e[mr[p][3:0]] = 1'b1;
    return e;
  endfunction

  task automatic sweep(string tag);
    for (int lv = 0; lv < 16; lv++) begin
      pirq_lvl = 4'(lv);
      step();
      chk(tag, 32'(irq_out), 32'(exp_irq(pirq_lvl)));
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mr[i] = 8'h80;
    step(); step();
    rst = 0;
    #1;
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 read", cfg_rdata, 32'h80808080);

    sweep("R6 all disabled");
    wr(8'h60, 32'h06050403, 4'hf); sweep("R4 distinct");
    wr(8'h61, 32'h09090909, 4'hf); sweep("R5 shared");
    wr(8'h60, 32'h0F1000FF, 4'hf); sweep("R6 threshold");
    wr(8'h60, 32'h02028002, 4'hf); sweep("R5 mixed");

    pirq_lvl = 4'hf;
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 40; r++) begin
        wr(8'h60, {4{8'(r)}}, 4'(1 << p));
        step();
        chk("R4 route sweep", 32'(irq_out), 32'(exp_irq(pirq_lvl)));
        q_pin = 2'(p); #1;
        chk("R9 q_en", 32'(q_en), 32'(r < 16));
        chk("R9 q_irq", 32'(q_irq), (r < 16) ? 32'(r) : 0);
      end

    wr(8'h60, 32'h80808003, 4'hf);
    pirq_lvl = 4'b0001; step();
    chk("R4 line A", 32'(irq_out), 32'h0008);
    wr(8'h60, 32'h80808007, 4'h1);
    chk("R7 rebuild edge", 32'(irq_out), 32'h0080);
    wr(8'h60, 32'h80808080, 4'h1);
    chk("R7 drop edge", 32'(irq_out), 32'h0000);
    wr(8'h60, 32'h8080800C, 4'h1);
    chk("R7 reroute", 32'(irq_out), 32'h1000);

    wr(8'h64, 32'h01010101, 4'hf);
    step();
    chk("R2 other word", cfg_rdata, {mr[3], mr[2], mr[1], mr[0]});
    chk("R2 other word irq", 32'(irq_out), 32'h1000);
    wr(8'h60, 32'h01010101, 4'h0);
    step();
    chk("R2 no lanes", cfg_rdata, 32'h8080800C);
    chk("R2 no lanes irq", 32'(irq_out), 32'h1000);
    wr(8'h63, 32'h05000000, 4'h8);
    chk("R2 lane D", cfg_rdata, 32'h0580800C);

    for (int a = 0; a < 256; a++) begin
      cfg_addr = 8'(a); #1;
      chk("R3 read", cfg_rdata, (a[7:2] == 6'h18) ? {mr[3], mr[2], mr[1], mr[0]} : 32'h0);
    end
    cfg_addr = 8'h60;

    for (int s = 0; s < 32; s++)
      for (int n = 0; n < 4; n++) begin
        slot = 5'(s); intx_pin = 2'(n); #1;
        chk("R8 fold", 32'(pirq_idx), 32'((n + s + 3) % 4));
      end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule